// File: doc/BRIEF.md
# Flash Program Suspend Controller

This block is the command front end of a parallel NOR flash model. A host issues bus write cycles that carry command bytes. The block decodes them, runs a modelled program operation as a fixed run of algorithm steps, and writes the programmed byte into a small storage array when the last step finishes. The `ready` output is high whenever the write state machine is not busy. Reads come from one of two sources, picked by an internal read-mode flag: the storage array addressed by `rd_addr`, or an 8-bit status byte.

A program in flight can be suspended. The suspend request is held until the algorithm reaches its next pause point, and only then does the operation stop. While it is stopped, the host may read other array locations or poll status, and it then resumes the program. The rest of the program runs from the step where it stopped. Commands that are not legal in the current state are dropped without any side effect.

Top module: `flash_psus_ctrl`

## Requirements
- R1: After reset, `ready` is 1, reads return array data, and every array location reads 0x00.
- R2: Writing 0x40 and then a data byte to address A starts a program that keeps `ready` low for exactly STEPS (16) clocks after the data write. After that, location A reads back the data byte.
- R3: Status byte layout: bit 7 is ready (1 = not busy) and bit 2 is program-suspended. All other bits are 0. Writing 0x70 selects status reads and 0xFF selects array reads. The program setup, the data write, an accepted suspend and an accepted resume each select status reads.
- R4: Writing 0xB0 while busy takes effect only at a pause point, where the number of finished steps is a multiple of PAUSE_GAP (4) and below STEPS. `ready` rises within 4 clocks of the command. If the program ends first, it completes normally and is not suspended.
- R5: While suspended, `ready` is 1 and the status byte reads 0x84.
- R6: While suspended, only 0xFF, 0x70 and 0xD0 are accepted. Any other byte (for example 0x40 or 0xB0) leaves the suspended state, the read mode and the status unchanged.
- R7: While suspended, array reads return stored data at other locations. The location being programmed still holds its old value.
- R8: Writing 0xD0 while suspended clears status bits 7 and 2 (status reads 0x00) and drives `ready` low. The program then finishes after STEPS minus the number of steps already done.
- R9: Writing 0xB0 or 0xD0 while idle has no effect: `ready` stays 1, the read mode is unchanged, and a later status read shows 0x80.
- R10: While a program is running, only 0x70 and 0xB0 are accepted. Any other byte is ignored, so reads stay on status and the program's data is not altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per command byte |
| wr_data | input | 8 | Command byte or program data |
| wr_addr | input | AW | Target address that goes with the program data byte |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array data or status byte, by read mode |
| ready | output | 1 | High when the write state machine is not busy |

## Verification
The assertions check on every cycle that:
- a suspend lands only on a pause-point step count;
- the wait for a pause point never goes past PAUSE_GAP clocks;
- the step count stays frozen while suspended;
- any byte other than resume keeps the controller suspended;
- a resume drops `ready` and selects a zero status;
- suspend in the idle state does nothing.

Only the bench's scenarios can show the exact suspend latency for each offset into the program, the case where the program finishes before a pause point, the remaining busy time after resume, and which data each array location holds before and after a suspended program completes.

// File: rtl/psus_pkg.sv
package psus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BUSY  = 2'd2,
    ST_SUSP  = 2'd3
  } eng_st_t;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_SUSP     = 8'hB0;
  localparam logic [7:0] CMD_RESUME   = 8'hD0;

  localparam int SR_READY_BIT = 7;
  localparam int SR_SUSP_BIT  = 2;

  // A step count that is one short of a multiple of the gap is a pause point,
  // except for the final step, which always completes.
  function automatic logic at_pause_point(input int unsigned step,
                                          input int unsigned steps,
                                          input int unsigned gap);
    return ((step % gap) == gap - 1) && (step != steps - 1);
  endfunction

  function automatic logic [7:0] make_status(input logic rdy, input logic susp);
    logic [7:0] s;
    s = '0;
    s[SR_READY_BIT] = rdy;
    s[SR_SUSP_BIT]  = susp;
    return s;
  endfunction

endpackage

// File: rtl/psus_cmd_dec.sv
module psus_cmd_dec
  import psus_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  eng_st_t    st,
  output logic       take_data,
  output logic       do_setup,
  output logic       do_rd_array,
  output logic       do_rd_stat,
  output logic       do_susp,
  output logic       do_resume
);

  always_comb begin
    take_data   = 1'b0;
    do_setup    = 1'b0;
    do_rd_array = 1'b0;
    do_rd_stat  = 1'b0;
    do_susp     = 1'b0;
    do_resume   = 1'b0;
    if (wr_en) begin
      unique case (st)
        ST_IDLE: begin
          do_rd_array = (wr_data == CMD_RD_ARRAY);
          do_rd_stat  = (wr_data == CMD_RD_STAT);
          do_setup    = (wr_data == CMD_PROG);
        end
        ST_SETUP: take_data = 1'b1;
        ST_BUSY: begin
          do_rd_stat = (wr_data == CMD_RD_STAT);
          do_susp    = (wr_data == CMD_SUSP);
        end
        ST_SUSP: begin
          // R6: restricted command set while suspended
          do_rd_array = (wr_data == CMD_RD_ARRAY);
          do_rd_stat  = (wr_data == CMD_RD_STAT);
          do_resume   = (wr_data == CMD_RESUME);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/psus_prog_engine.sv
module psus_prog_engine
  import psus_pkg::*;
#(
  parameter int AW        = 4,
  parameter int STEPS     = 16,
  parameter int PAUSE_GAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_setup,
  input  logic          take_data,
  input  logic          do_susp,
  input  logic          do_resume,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] wr_addr,
  output eng_st_t       st,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [7:0]    commit_data
);

  localparam int SW = $clog2(STEPS);
  localparam int LW = $clog2(PAUSE_GAP + 2);

  eng_st_t       st_q;
  logic [SW-1:0] step_q;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [LW-1:0] lat_q;

  wire last_step = (st_q == ST_BUSY) && (step_q == SW'(STEPS - 1));
  wire pause_hit = (st_q == ST_BUSY) && req_q &&
                   at_pause_point(32'(step_q), STEPS, PAUSE_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (do_setup) st_q <= ST_SETUP;
        ST_SETUP: if (take_data) begin
          addr_q <= wr_addr;
          data_q <= wr_data;
          step_q <= '0;
          req_q  <= 1'b0;
          st_q   <= ST_BUSY;
        end
        ST_BUSY: begin
          if (do_susp) req_q <= 1'b1;
          if (last_step) begin
            st_q  <= ST_IDLE;
            req_q <= 1'b0;
          end else begin
            step_q <= step_q + SW'(1);
            if (pause_hit) begin
              st_q  <= ST_SUSP;
              req_q <= 1'b0;
            end
          end
        end
        ST_SUSP: if (do_resume) st_q <= ST_BUSY;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Cycles spent waiting for a pause point; used only by the latency check.
  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (st_q == ST_BUSY && req_q) lat_q <= lat_q + LW'(1);
    else lat_q <= '0;
  end

  assign st          = st_q;
  assign commit      = last_step;
  assign commit_addr = addr_q;
  assign commit_data = data_q;

  p_pause_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_SUSP) |-> ((32'(step_q) % PAUSE_GAP) == 0))
    else $error("suspend outside a pause point");

  p_pause_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q <= LW'(PAUSE_GAP))
    else $error("suspend latency too long");

  p_step_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && !do_resume) |=> $stable(step_q))
    else $error("step count moved while suspended");

  p_resume_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && do_resume) |=> (st_q == ST_BUSY))
    else $error("resume did not restart program");

endmodule

// File: rtl/psus_array.sv
module psus_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/flash_psus_ctrl.sv
module flash_psus_ctrl
  import psus_pkg::*;
#(
  parameter int AW        = 4,
  parameter int STEPS     = 16,
  parameter int PAUSE_GAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          ready
);

  eng_st_t       eng_st;
  logic          take_data, do_setup, do_rd_array, do_rd_stat, do_susp, do_resume;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [7:0]    commit_data;
  logic [7:0]    arr_rd;
  logic          rd_status_q;
  logic [7:0]    status;

  psus_cmd_dec u_dec (
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .st         (eng_st),
    .take_data  (take_data),
    .do_setup   (do_setup),
    .do_rd_array(do_rd_array),
    .do_rd_stat (do_rd_stat),
    .do_susp    (do_susp),
    .do_resume  (do_resume)
  );

  psus_prog_engine #(.AW(AW), .STEPS(STEPS), .PAUSE_GAP(PAUSE_GAP)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_setup   (do_setup),
    .take_data  (take_data),
    .do_susp    (do_susp),
    .do_resume  (do_resume),
    .wr_data    (wr_data),
    .wr_addr    (wr_addr),
    .st         (eng_st),
    .commit     (commit),
    .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  psus_array #(.AW(AW), .DW(8)) u_arr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (commit),
    .waddr(commit_addr),
    .wdata(commit_data),
    .raddr(rd_addr),
    .rdata(arr_rd)
  );

  // R3: read-mode selection
  always_ff @(posedge clk) begin
    if (!rst_n) rd_status_q <= 1'b0;
    else if (do_rd_array) rd_status_q <= 1'b0;
    else if (do_rd_stat | do_setup | take_data | do_susp | do_resume)
      rd_status_q <= 1'b1;
  end

  assign ready   = (eng_st != ST_BUSY);
  assign status  = make_status(ready, eng_st == ST_SUSP);
  assign rd_data = rd_status_q ? status : arr_rd;

  p_susp_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_st == ST_SUSP && rd_status_q) |-> (ready && rd_data == 8'h84))
    else $error("suspended status wrong");

  p_susp_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_st == ST_SUSP && !do_resume) |=> (eng_st == ST_SUSP))
    else $error("left suspend without resume");

  p_resume_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_resume |=> (!ready && rd_status_q && rd_data == 8'h00))
    else $error("resume did not clear status");

  p_idle_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_st == ST_IDLE && wr_en && wr_data == CMD_SUSP) |=> (eng_st == ST_IDLE && ready))
    else $error("idle suspend had an effect");

endmodule

// File: tb/flash_psus_ctrl_test.sv
module flash_psus_ctrl_test;

  localparam int CLK_P = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          ready;

  int checks = 0;
  int errors = 0;

  flash_psus_ctrl #(.AW(AW), .STEPS(16), .PAUSE_GAP(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!ready && n < 64) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 ready after reset", ready, 1);
    rd_addr = 4'd5;
    #1 check("R1 array reads zero", rd_data, 8'h00);
  endtask

  task automatic t_program();
    int n;
    wr(8'h40, 0);
    wr(8'h5A, 4'd3);
    check("R3 status while busy", rd_data, 8'h00);
    count_busy(n);
    check("R2 busy length", n, 16);
    check("R3 status when done", rd_data, 8'h80);
    wr(8'hFF, 0);
    rd_addr = 4'd3;
    #1 check("R2 programmed data", rd_data, 8'h5A);
    wr(8'h70, 0);
    check("R3 read status cmd", rd_data, 8'h80);
  endtask

  task automatic t_busy_ignore();
    int n;
    wr(8'h40, 0);
    wr(8'h11, 4'd6);
    wr(8'hFF, 0);
    check("R10 read array ignored while busy", rd_data, 8'h00);
    wr(8'h40, 0);
    wr(8'h99, 4'd6);
    count_busy(n);
    check("R10 status after busy", rd_data, 8'h80);
    wr(8'hFF, 0);
    rd_addr = 4'd6;
    #1 check("R10 data not altered", rd_data, 8'h11);
  endtask

  task automatic t_suspend(input int gap, input logic [AW-1:0] tgt, input logic [7:0] d);
    int n, j, s, old, d0;
    bit will_susp;
    wr(8'h40, 0);
    wr(d, tgt);
    repeat (gap) @(negedge clk);
    d0 = gap + 1;
    will_susp = 0; j = 0; s = 0;
    for (int k = 1; k <= 8; k++) begin
      old = d0 + k - 1;
      if (old == 15) begin j = k; break; end
      if ((old % 4) == 3) begin j = k; will_susp = 1; s = old + 1; break; end
    end
    wr(8'hB0, 0);
    count_busy(n);
    check("R4 suspend latency", n, j);
    if (will_susp) begin
      check("R5 ready while suspended", ready, 1);
      check("R5 status 0x84", rd_data, 8'h84);
      wr(8'hFF, 0);
      rd_addr = 4'd3;
      #1 check("R7 other location readable", rd_data, 8'h5A);
      rd_addr = tgt;
      #1 check("R7 target still old", rd_data, 8'h00);
      wr(8'h40, 0);
      rd_addr = 4'd3;
      #1 check("R6 setup ignored keeps array mode", rd_data, 8'h5A);
      wr(8'hB0, 0);
      #1 check("R6 suspend ignored keeps array mode", rd_data, 8'h5A);
      check("R6 still ready", ready, 1);
      wr(8'h70, 0);
      check("R6 still suspended", rd_data, 8'h84);
      wr(8'hD0, 0);
      check("R8 resume status", rd_data, 8'h00);
      check("R8 resume busy", ready, 0);
      count_busy(n);
      check("R8 remaining steps", n, 16 - s);
    end
    check("R4 status after finish", rd_data, 8'h80);
    wr(8'hFF, 0);
    rd_addr = tgt;
    #1 check("R8 data after finish", rd_data, d);
  endtask

  task automatic t_idle_cmds();
    rd_addr = 4'd3;
    wr(8'hB0, 0);
    check("R9 idle suspend ready", ready, 1);
    #1 check("R9 idle suspend keeps array mode", rd_data, 8'h5A);
    wr(8'hD0, 0);
    #1 check("R9 idle resume keeps array mode", rd_data, 8'h5A);
    wr(8'h70, 0);
    check("R9 not suspended", rd_data, 8'h80);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_busy_ignore();
    t_suspend(0, 4'd8, 8'hA5);
    t_suspend(2, 4'd9, 8'h3C);
    t_suspend(5, 4'd10, 8'hC3);
    t_suspend(13, 4'd11, 8'h77);
    t_idle_cmds();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule